// File: doc/BRIEF.md
# Three-Stage Radix-2 Butterfly Transform, 8 Points

This block computes an eight-point discrete Fourier transform, forward or inverse, on complex fixed-point samples. Eight complex samples arrive together on one cycle with a valid strobe. They pass through three registered butterfly stages that decimate in frequency. Each stage has four butterflies. In every butterfly the upper output is the sum of the two inputs. The lower output is their difference times a twiddle factor. The first stage uses four distinct twiddles, the second stage uses two, and the last stage uses one.

A new vector can be accepted on every cycle. Each vector carries its own direction bit down the pipeline, so forward and inverse vectors can be interleaved freely. Results leave in bit-reversed bin order and carry a valid strobe. Twiddles come from a fixed internal table in Q1.14 format. Sums and rounded products are saturated to the sample width.

Top module: `fft8_dif_core`

## Requirements
- R1: `out_vld` is high exactly three clock cycles after a cycle in which `in_vld` was high, and is low in every other cycle, for any pattern of `in_vld`, including a vector on every cycle.
- R2: In forward mode (`in_inv` = 0), output bin k equals the sum over n of x[n]·e^(−j2πkn/8). Input lane n sits in bits [16n+15:16n] of `in_re` and `in_im`. Each twiddle product is rounded half-up at 14 fractional bits, so results stay within a few LSB of the exact value.
- R3: In inverse mode (`in_inv` = 1), the twiddles are conjugated. Every final output is then shifted arithmetically right by 3, which gives (1/8)·Σ x[n]·e^(+j2πkn/8) rounded toward minus infinity, so every lane lies in [−4096, 4095].
- R4: Output lane p, in bits [16p+15:16p] of `out_re` and `out_im`, holds bin bitrev3(p), so the lanes hold bins 0,4,2,6,1,5,3,7 in that order.
- R5: Every butterfly sum and every rounded product saturates to [−32768, 32767]. For example, eight real inputs of 30000 give 32767 in lane 0 and 0 in every other lane, and eight inputs of −30000 give −32768 in lane 0.
- R6: The direction bit is sampled together with `in_vld`, and each vector is transformed in its own direction even when the direction changes on consecutive cycles.
- R7: While `rst` is high and after it falls, `out_vld` is low and `out_re`/`out_im` are zero until the first result arrives.
- R8: While `out_vld` is low, `out_re` and `out_im` keep the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input vector strobe |
| in_inv | input | 1 | Direction: 0 forward, 1 inverse |
| in_re | input | 128 | Real parts, lane n at bits [16n+15:16n] |
| in_im | input | 128 | Imaginary parts, same lane layout |
| out_vld | output | 1 | Result strobe |
| out_re | output | 128 | Real parts of bins in bit-reversed lane order |
| out_im | output | 128 | Imaginary parts, same lane layout |

## Verification
Forward and inverse vectors can occupy neighbouring pipeline stages in the same cycle. Each must pick its own twiddle signs and its own final scaling. The bench provokes this by toggling `in_inv` on every cycle of an unbroken run of random vectors. It judges each output against a floating-point DFT in the direction that vector entered with. Saturating vectors and gaps in the valid stream are mixed in, so that the same cycle also carries clipped results and held outputs.

// File: rtl/fft8_dif_pkg.sv
package fft8_dif_pkg;
  localparam int DW      = 16;
  localparam int TWW     = 16;
  localparam int TFRAC   = 14;
  localparam int NPT     = 8;
  localparam int NSTG    = 3;
  localparam int NBF     = NPT / 2;
  localparam int WIDE    = 2 * DW + 4;
  localparam int TW_ONE  = 1 << TFRAC;
  localparam int TW_DIAG = 11585;  // round(2^14 / sqrt(2))
  localparam int SMP_MAX = (1 << (DW - 1)) - 1;
  localparam int SMP_MIN = -(1 << (DW - 1));

  typedef logic signed [DW-1:0]   smp_t;
  typedef logic signed [TWW-1:0]  tw_t;
  typedef logic signed [WIDE-1:0] wide_t;
  typedef struct packed { smp_t re; smp_t im; } cplx_t;
  typedef struct packed { tw_t re;  tw_t im;  } twid_t;

  // clamp a wide value into the sample range
  function automatic smp_t sat_smp(wide_t v);
    if (v > wide_t'(SMP_MAX)) return smp_t'(SMP_MAX);
    if (v < wide_t'(SMP_MIN)) return smp_t'(SMP_MIN);
    return smp_t'(v);
  endfunction

  // W8^k for k in 0..3, conjugated when inv is set
  function automatic twid_t twiddle(int k, logic inv);
    twid_t w;
    case (k & 3)
      0:       begin w.re = tw_t'(TW_ONE);   w.im = tw_t'(0);        end
      1:       begin w.re = tw_t'(TW_DIAG);  w.im = tw_t'(-TW_DIAG); end
      2:       begin w.re = tw_t'(0);        w.im = tw_t'(-TW_ONE);  end
      default: begin w.re = tw_t'(-TW_DIAG); w.im = tw_t'(-TW_DIAG); end
    endcase
    if (inv) w.im = -w.im;
    return w;
  endfunction

  // saturating complex sum
  function automatic cplx_t cadd_sat(cplx_t a, cplx_t b);
    cplx_t r;
    r.re = sat_smp(wide_t'(a.re) + wide_t'(b.re));
    r.im = sat_smp(wide_t'(a.im) + wide_t'(b.im));
    return r;
  endfunction

  // (a - b) * w, rounded half-up at TFRAC bits and saturated
  function automatic cplx_t csub_mul(cplx_t a, cplx_t b, twid_t w);
    wide_t dre, dim, pre, pim;
    cplx_t r;
    dre = wide_t'(a.re) - wide_t'(b.re);
    dim = wide_t'(a.im) - wide_t'(b.im);
    pre = dre * wide_t'(w.re) - dim * wide_t'(w.im);
    pim = dre * wide_t'(w.im) + dim * wide_t'(w.re);
    pre = (pre + wide_t'(1 << (TFRAC - 1))) >>> TFRAC;
    pim = (pim + wide_t'(1 << (TFRAC - 1))) >>> TFRAC;
    r.re = sat_smp(pre);
    r.im = sat_smp(pim);
    return r;
  endfunction

  // inverse-mode scaling by 1/NPT
  function automatic cplx_t cscale_inv(cplx_t a);
    cplx_t r;
    r.re = a.re >>> NSTG;
    r.im = a.im >>> NSTG;
    return r;
  endfunction
endpackage

// File: rtl/fft8_bfly.sv
module fft8_bfly
  import fft8_dif_pkg::*;
(
  input  cplx_t a,
  input  cplx_t b,
  input  twid_t w,
  output cplx_t up,
  output cplx_t lo
);
  always_comb begin
    up = cadd_sat(a, b);
    lo = csub_mul(a, b, w);
  end
endmodule

// File: rtl/fft8_stage.sv
module fft8_stage
  import fft8_dif_pkg::*;
#(
  parameter int STG  = 0,
  parameter bit LAST = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             i_vld,
  input  logic             i_inv,
  input  cplx_t [NPT-1:0]  i_d,
  output logic             o_vld,
  output logic             o_inv,
  output cplx_t [NPT-1:0]  o_d
);
  localparam int SPAN = (NPT / 2) >> STG;

  cplx_t [NPT-1:0] nxt;
  cplx_t [NPT-1:0] fin;

  for (genvar b = 0; b < NBF; b++) begin : g_bf
    localparam int J   = b % SPAN;
    localparam int TOP = (b / SPAN) * 2 * SPAN + J;
    localparam int BOT = TOP + SPAN;
    twid_t w;
    assign w = twiddle(J << STG, i_inv);
    fft8_bfly u_bf (
      .a  (i_d[TOP]),
      .b  (i_d[BOT]),
      .w  (w),
      .up (nxt[TOP]),
      .lo (nxt[BOT])
    );
  end

  for (genvar l = 0; l < NPT; l++) begin : g_fin
    if (LAST) begin : g_scl
      assign fin[l] = i_inv ? cscale_inv(nxt[l]) : nxt[l];
    end else begin : g_pass
      assign fin[l] = nxt[l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld <= 1'b0;
      o_inv <= 1'b0;
      o_d   <= '0;
    end else begin
      o_vld <= i_vld;
      if (i_vld) begin
        o_inv <= i_inv;
        o_d   <= fin;
      end
    end
  end
endmodule

// File: rtl/fft8_dif_core.sv
module fft8_dif_core
  import fft8_dif_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_vld,
  input  logic               in_inv,
  input  logic [NPT*DW-1:0]  in_re,
  input  logic [NPT*DW-1:0]  in_im,
  output logic               out_vld,
  output logic [NPT*DW-1:0]  out_re,
  output logic [NPT*DW-1:0]  out_im
);
  logic            vld_p [NSTG+1];
  logic            inv_p [NSTG+1];
  cplx_t [NPT-1:0] dat_p [NSTG+1];
  logic            out_mode;  // direction of the vector now at the output

  for (genvar l = 0; l < NPT; l++) begin : g_lane
    assign dat_p[0][l].re = in_re[l*DW +: DW];
    assign dat_p[0][l].im = in_im[l*DW +: DW];
    assign out_re[l*DW +: DW] = dat_p[NSTG][l].re;
    assign out_im[l*DW +: DW] = dat_p[NSTG][l].im;
  end

  assign vld_p[0] = in_vld;
  assign inv_p[0] = in_inv;

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    fft8_stage #(
      .STG  (s),
      .LAST (s == NSTG - 1)
    ) u_stg (
      .clk   (clk),
      .rst   (rst),
      .i_vld (vld_p[s]),
      .i_inv (inv_p[s]),
      .i_d   (dat_p[s]),
      .o_vld (vld_p[s+1]),
      .o_inv (inv_p[s+1]),
      .o_d   (dat_p[s+1])
    );
  end

  assign out_vld  = vld_p[NSTG];
  assign out_mode = inv_p[NSTG];
endmodule

// File: rtl/fft8_dif_chk.sv
module fft8_dif_chk
  import fft8_dif_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_vld,
  input logic              in_inv,
  input logic              out_vld,
  input logic              out_mode,
  input logic [NPT*DW-1:0] out_re,
  input logic [NPT*DW-1:0] out_im
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_vld |-> ##3 out_vld); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (age == 2'd3) && $past(in_vld, 3)); // R1
  AST_MODE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (out_mode == $past(in_inv, 3))); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> ($stable(out_re) && $stable(out_im))); // R8

  for (genvar l = 0; l < NPT; l++) begin : g_rng
    AST_INV_RANGE: assert property (@(posedge clk) disable iff (rst)
      (out_vld && out_mode) |->
        ($signed(out_re[l*DW +: DW]) >= -16'sd4096 && $signed(out_re[l*DW +: DW]) <= 16'sd4095 &&
         $signed(out_im[l*DW +: DW]) >= -16'sd4096 && $signed(out_im[l*DW +: DW]) <= 16'sd4095)); // R3
  end
endmodule

bind fft8_dif_core fft8_dif_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_vld   (in_vld),
  .in_inv   (in_inv),
  .out_vld  (out_vld),
  .out_mode (out_mode),
  .out_re   (out_re),
  .out_im   (out_im)
);

// File: tb/sim_fft8_dif_core.sv
`timescale 1ns/1ps
module sim_fft8_dif_core;
  typedef int  vec8_t [8];
  typedef real rvec8_t [8];
  typedef struct { rvec8_t er; rvec8_t ei; int tol; string tag; } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_vld = 1'b0;
  logic         in_inv = 1'b0;
  logic [127:0] in_re = '0;
  logic [127:0] in_im = '0;
  logic         out_vld;
  logic [127:0] out_re, out_im;

  int checks = 0;
  int fails  = 0;
  bit vq[$];
  exp_t eq[$];
  bit have_last = 0;
  logic [127:0] last_re, last_im;

  always #4 clk = ~clk;  // 125 MHz

  fft8_dif_core u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_inv(in_inv),
    .in_re(in_re), .in_im(in_im),
    .out_vld(out_vld), .out_re(out_re), .out_im(out_im)
  );

  function automatic int brev3(int p);
    return ((p & 1) << 2) | (p & 2) | ((p >> 2) & 1);
  endfunction

  function automatic real clamp16(real v);
    if (v > 32767.0) return 32767.0;
    if (v < -32768.0) return -32768.0;
    return v;
  endfunction

  // floating-point DFT, bins placed in bit-reversed lanes (R2, R3, R4)
  function automatic exp_t ref_dft(vec8_t xr, vec8_t xi, bit inv, int tol, string tag);
    exp_t e;
    for (int p = 0; p < 8; p++) begin
      int  k = brev3(p);
      real sr = 0.0, si = 0.0;
      for (int n = 0; n < 8; n++) begin
        real a = 2.0 * 3.14159265358979 * k * n / 8.0;
        real c = $cos(a), s = $sin(a);
        if (!inv) begin
          sr += xr[n] * c + xi[n] * s;
          si += xi[n] * c - xr[n] * s;
        end else begin
          sr += xr[n] * c - xi[n] * s;
          si += xi[n] * c + xr[n] * s;
        end
      end
      if (inv) begin sr = sr / 8.0; si = si / 8.0; end
      e.er[p] = clamp16(sr);
      e.ei[p] = clamp16(si);
    end
    e.tol = tol;
    e.tag = tag;
    return e;
  endfunction

  task automatic lane_chk(string tag, int p, string part, int act, real expv, int tol);
    real d = act - expv;
    checks++;
    if (d > tol || d < -tol) begin
      fails++;
      $display("FAIL %s lane %0d %s actual %0d expected %0f", tag, p, part, act, expv);
    end
  endtask

  task automatic observe();
    bit ev = 0;
    if (vq.size() == 3) ev = vq.pop_front();
    checks++;  // R1: valid timing
    if (out_vld !== ev) begin
      fails++;
      $display("FAIL R1 out_vld actual %0b expected %0b", out_vld, ev);
    end
    if (ev) begin
      exp_t e = eq.pop_front();
      for (int p = 0; p < 8; p++) begin
        lane_chk(e.tag, p, "re", int'($signed(out_re[p*16 +: 16])), e.er[p], e.tol);
        lane_chk(e.tag, p, "im", int'($signed(out_im[p*16 +: 16])), e.ei[p], e.tol);
      end
    end else if (have_last) begin
      checks++;  // R8: hold while idle
      if (out_re !== last_re || out_im !== last_im) begin
        fails++;
        $display("FAIL R8 outputs changed while idle actual %h expected %h", out_re, last_re);
      end
    end
    if (out_vld === 1'b1) begin
      have_last = 1;
      last_re = out_re;
      last_im = out_im;
    end
  endtask

  task automatic step(bit v, bit md, vec8_t xr, vec8_t xi, string tag);
    @(negedge clk);
    observe();
    in_vld = v;
    in_inv = md;
    for (int n = 0; n < 8; n++) begin
      in_re[n*16 +: 16] = 16'(xr[n]);
      in_im[n*16 +: 16] = 16'(xi[n]);
    end
    vq.push_back(v);
    if (v) eq.push_back(ref_dft(xr, xi, md, md ? 2 : 6, tag));
  endtask

  task automatic idle(int n);
    vec8_t z = '{default: 0};
    for (int i = 0; i < n; i++) step(0, 0, z, z, "idle");
  endtask

  function automatic vec8_t rnd_vec();
    vec8_t v;
    for (int n = 0; n < 8; n++) v[n] = int'($urandom_range(4000)) - 2000;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    vec8_t xr, xi, z;
    z = '{default: 0};
    repeat (3) @(negedge clk);
    checks++;  // R7: reset state
    if (out_vld !== 1'b0 || out_re !== '0 || out_im !== '0) begin
      fails++;
      $display("FAIL R7 reset state actual vld=%b re=%h expected 0", out_vld, out_re);
    end
    rst = 0;

    // R2: impulses
    xr = z; xr[0] = 1000; step(1, 0, xr, z, "R2");
    xr = z; xr[1] = 1000; xi = z; xi[1] = -500; step(1, 0, xr, xi, "R2");
    idle(4);

    // R4: tone at bin 3 lands in lane 6
    for (int n = 0; n < 8; n++) xr[n] = int'($rtoi(1000.0 * $cos(2.0 * 3.14159265358979 * 3 * n / 8.0)));
    step(1, 0, xr, z, "R4");
    idle(1);

    // R2: back-to-back random forward vectors
    for (int i = 0; i < 12; i++) step(1, 0, rnd_vec(), rnd_vec(), "R2");
    idle(4);

    // R3: inverse vectors with gaps
    for (int i = 0; i < 8; i++) begin
      step(1, 1, rnd_vec(), rnd_vec(), "R3");
      if (i % 3 == 0) idle(1);
    end
    idle(4);

    // R5: saturation both signs
    xr = '{default: 30000};  step(1, 0, xr, z, "R5");
    xr = '{default: -30000}; step(1, 0, xr, z, "R5");
    idle(4);

    // R6: direction toggles every cycle
    for (int i = 0; i < 16; i++) step(1, i[0], rnd_vec(), rnd_vec(), "R6");
    xr = '{default: 30000}; step(1, 0, xr, z, "R6");
    step(1, 1, rnd_vec(), rnd_vec(), "R6");
    idle(6);  // R8 hold checked in idle cycles

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule